// File: doc/BRIEF.md
# Bit-split multi-pattern payload matcher

This block scans a packet payload for a fixed set of byte patterns, taking one payload byte per clock. The byte is not fed whole to one large automaton. Instead it is cut into small bit groups, and each group drives its own small deterministic automaton, called a tile. All tiles share the same shape. Each tile takes its group of bit positions through a set of programmable 8:1 selectors. It advances through its own next-state table and reads a per-state partial match vector with one bit per pattern. The block ANDs the partial vectors of all tiles. A bit of the result is set when every tile agrees that the pattern with that index has just ended.

Software builds the tables offline. This covers the per-tile automata with failure edges already folded into the next-state entries, the partial match vectors, and the choice of bit groups. Software loads them through a write port while no bytes are flowing. An asserted restart at the first byte of a packet returns every tile to its initial state. The result appears one cycle after each accepted byte.

Top module: `bitsplit_matcher`

## Requirements
- R1: After reset, out_valid and any_match are low and match_vec is zero. Input bit j of tile t selects byte bit t*GRP_W+j, counted from 0 at the LSB. With four 2-bit tiles, tile 0 therefore sees bits 1:0 and tile 3 sees bits 7:6.
- R2: out_valid is high in exactly the cycle after each cycle with in_valid high, and low otherwise.
- R3: Suppose the loaded tables encode the patterns for the loaded bit grouping. Then bit i of match_vec, valid with out_valid, is set exactly when pattern i ends at the accepted byte within the current packet. This bit is the AND over tiles of bit i of each tile's partial vector for its new state.
- R4: any_match equals the OR of all bits of match_vec in every cycle.
- R5: With restart high, every tile returns to state 0. If in_valid is high in the same cycle, that byte is processed from state 0 as the first byte of a new packet.
- R6: A configuration write (cfg_we high) in a cycle with in_valid high is ignored and leaves all tables and selections unchanged.
- R7: The bit selections may be reloaded to any grouping, for example 0-based groups (7,3),(6,2),(5,4),(1,0). Matching then follows the new grouping.
- R8: The write port is encoded by cfg_kind. Value 0 writes next-state entry (cfg_tile, cfg_state, cfg_sym) with cfg_data[PTR_W-1:0]. Value 1 writes the partial vector of (cfg_tile, cfg_state) with cfg_data. Value 2 writes selector cfg_sym of cfg_tile with byte bit position cfg_data[2:0]. Value 3 does nothing. A tile symbol has bit j taken from its selector j.
- R9: In cycles without an accepted byte, tile states, match_vec and any_match hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Start of packet: tiles back to state 0 |
| in_valid | input | 1 | Payload byte present |
| in_byte | input | SYM_W | Payload byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 next state, 1 partial vector, 2 selector |
| cfg_tile | input | clog2(SYM_W/GRP_W) | Tile addressed |
| cfg_state | input | clog2(STATES) | State addressed |
| cfg_sym | input | GRP_W | Input symbol, or selector index for kind 2 |
| cfg_data | input | PAT_W | Write data |
| out_valid | output | 1 | Result for the byte of the previous cycle |
| match_vec | output | PAT_W | Per-pattern match result |
| any_match | output | 1 | Some bit of match_vec is set |

## Verification
The bench builds the block with four 2-bit tiles, 16 states per tile and a 4-bit pattern vector. These sizes let it build every tile automaton for the patterns "he", "has", "his" and "hers" arithmetically for any bit grouping and load every table entry completely. A byte-history model judges each output independently of the automata. The bench streams directed and random bytes over an alphabet dense in pattern characters. The streams include gaps, restarts and write attempts during streaming, first under the reset grouping and then under a crossed grouping.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  typedef enum logic [1:0] {
    CFG_NEXT = 2'd0,
    CFG_PMV  = 2'd1,
    CFG_SEL  = 2'd2,
    CFG_NOP  = 2'd3
  } cfg_kind_e;
endpackage

// File: rtl/bsm_sel_bank.sv
// Per-tile bank of bit-position selections, reset to a straight split.
module bsm_sel_bank #(
  parameter int SYM_W  = 8,
  parameter int GRP_W  = 2,
  parameter int TILE_I = 0,
  localparam int SEL_W = $clog2(SYM_W)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [GRP_W-1:0]      wr_idx,
  input  logic [SEL_W-1:0]      wr_pos,
  output logic [GRP_W*SEL_W-1:0] sel_flat
);
  logic [GRP_W-1:0][SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < GRP_W; j++) sel_q[j] <= SEL_W'(TILE_I*GRP_W + j);
    end else if (wr_en) begin
      for (int j = 0; j < GRP_W; j++)
        if (wr_idx == GRP_W'(j)) sel_q[j] <= wr_pos;
    end
  end

  assign sel_flat = sel_q;
endmodule

// File: rtl/bsm_bit_pick.sv
// One 8:1 style selector per tile input bit.
module bsm_bit_pick #(
  parameter int SYM_W  = 8,
  parameter int GRP_W  = 2,
  localparam int SEL_W = $clog2(SYM_W)
) (
  input  logic [SYM_W-1:0]       byte_i,
  input  logic [GRP_W*SEL_W-1:0] sel_flat,
  output logic [GRP_W-1:0]       sym_o
);
  for (genvar j = 0; j < GRP_W; j++) begin : g_pick
    assign sym_o[j] = byte_i[sel_flat[j*SEL_W +: SEL_W]];
  end
endmodule

// File: rtl/bsm_tile.sv
// One automaton tile: next-state table, partial match table, state register.
module bsm_tile #(
  parameter int GRP_W  = 2,
  parameter int STATES = 64,
  parameter int PAT_W  = 16,
  localparam int PTR_W  = $clog2(STATES),
  localparam int ADDR_W = PTR_W + GRP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             restart,
  input  logic [GRP_W-1:0] sym,
  input  logic             wr_next,
  input  logic             wr_pmv,
  input  logic [PTR_W-1:0] wr_state,
  input  logic [GRP_W-1:0] wr_sym,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PAT_W-1:0] wr_vec,
  output logic [PTR_W-1:0] state_o,
  output logic [PAT_W-1:0] pmv_next
);
  logic [PTR_W-1:0] trans_mem [1<<ADDR_W];
  logic [PAT_W-1:0] pmv_mem   [STATES];
  logic [PTR_W-1:0] state_q, cur, nxt;

  always_ff @(posedge clk) begin
    if (wr_next) trans_mem[{wr_state, wr_sym}] <= wr_ptr;
    if (wr_pmv)  pmv_mem[wr_state] <= wr_vec;
  end

  assign cur      = restart ? '0 : state_q;
  assign nxt      = trans_mem[{cur, sym}];
  assign pmv_next = pmv_mem[nxt];

  always_ff @(posedge clk) begin
    if (rst)          state_q <= '0;
    else if (step)    state_q <= nxt;
    else if (restart) state_q <= '0;
  end

  assign state_o = state_q;
endmodule

// File: rtl/bitsplit_matcher.sv
module bitsplit_matcher #(
  parameter int SYM_W  = 8,
  parameter int GRP_W  = 2,
  parameter int STATES = 64,
  parameter int PAT_W  = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              restart,
  input  logic                              in_valid,
  input  logic [SYM_W-1:0]                  in_byte,
  input  logic                              cfg_we,
  input  logic [1:0]                        cfg_kind,
  input  logic [$clog2(SYM_W/GRP_W)-1:0]    cfg_tile,
  input  logic [$clog2(STATES)-1:0]         cfg_state,
  input  logic [GRP_W-1:0]                  cfg_sym,
  input  logic [PAT_W-1:0]                  cfg_data,
  output logic                              out_valid,
  output logic [PAT_W-1:0]                  match_vec,
  output logic                              any_match
);
  import bsm_pkg::*;

  localparam int TILES  = SYM_W / GRP_W;
  localparam int TILE_W = $clog2(TILES);
  localparam int PTR_W  = $clog2(STATES);
  localparam int SEL_W  = $clog2(SYM_W);

  logic                          cfg_ok;
  cfg_kind_e                     kind;
  logic [TILES-1:0][PAT_W-1:0]   pmv;
  logic [TILES*PTR_W-1:0]        state_all;
  logic [PAT_W-1:0]              acc;
  logic                          valid_q, any_q;
  logic [PAT_W-1:0]              match_q;

  // configuration is accepted only while no byte is being consumed
  assign cfg_ok = cfg_we & ~in_valid;
  assign kind   = cfg_kind_e'(cfg_kind);

  for (genvar t = 0; t < TILES; t++) begin : g_tile
    logic                   hit;
    logic [GRP_W*SEL_W-1:0] sel_flat;
    logic [GRP_W-1:0]       sym;
    logic [PTR_W-1:0]       st;

    assign hit = cfg_ok && (cfg_tile == TILE_W'(t));

    bsm_sel_bank #(.SYM_W(SYM_W), .GRP_W(GRP_W), .TILE_I(t)) u_sel (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (hit && kind == CFG_SEL),
      .wr_idx   (cfg_sym),
      .wr_pos   (cfg_data[SEL_W-1:0]),
      .sel_flat (sel_flat)
    );

    bsm_bit_pick #(.SYM_W(SYM_W), .GRP_W(GRP_W)) u_pick (
      .byte_i   (in_byte),
      .sel_flat (sel_flat),
      .sym_o    (sym)
    );

    bsm_tile #(.GRP_W(GRP_W), .STATES(STATES), .PAT_W(PAT_W)) u_tile (
      .clk      (clk),
      .rst      (rst),
      .step     (in_valid),
      .restart  (restart),
      .sym      (sym),
      .wr_next  (hit && kind == CFG_NEXT),
      .wr_pmv   (hit && kind == CFG_PMV),
      .wr_state (cfg_state),
      .wr_sym   (cfg_sym),
      .wr_ptr   (cfg_data[PTR_W-1:0]),
      .wr_vec   (cfg_data),
      .state_o  (st),
      .pmv_next (pmv[t])
    );

    assign state_all[t*PTR_W +: PTR_W] = st;
  end

  // a pattern is present only when every tile reports it
  always_comb begin
    acc = '1;
    for (int t = 0; t < TILES; t++) acc &= pmv[t];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      match_q <= '0;
      any_q   <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        match_q <= acc;
        any_q   <= |acc;
      end
    end
  end

  assign out_valid = valid_q;
  assign match_vec = match_q;
  assign any_match = any_q;
endmodule

// File: rtl/bsm_checker.sv
module bsm_checker #(
  parameter int PAT_W = 16,
  parameter int ST_W  = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             restart,
  input logic             in_valid,
  input logic             out_valid,
  input logic [PAT_W-1:0] match_vec,
  input logic             any_match,
  input logic [ST_W-1:0]  state_all
);
  assert_valid_after_byte_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_any_is_or_R4: assert property (@(posedge clk) disable iff (rst)
    any_match == (|match_vec));

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(match_vec) && $stable(any_match));

  assert_restart_home_R5: assert property (@(posedge clk) disable iff (rst)
    (restart && !in_valid) |=> (state_all == '0));
endmodule

bind bitsplit_matcher bsm_checker #(.PAT_W(PAT_W), .ST_W(TILES*PTR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .restart   (restart),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .match_vec (match_vec),
  .any_match (any_match),
  .state_all (state_all)
);

// File: tb/tb_bitsplit_matcher.sv
`timescale 1ns/1ps
module tb_bitsplit_matcher;
  localparam int NT = 4;   // tiles
  localparam int NS = 16;  // states per tile
  localparam int NP = 4;   // patterns

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic restart = 1'b0, in_valid = 1'b0, cfg_we = 1'b0;
  logic [7:0] in_byte = '0;
  logic [1:0] cfg_kind = '0, cfg_tile = '0, cfg_sym = '0;
  logic [3:0] cfg_state = '0, cfg_data = '0;
  logic out_valid, any_match;
  logic [3:0] match_vec;

  always #2.5 clk = ~clk;

  bitsplit_matcher #(.SYM_W(8), .GRP_W(2), .STATES(NS), .PAT_W(NP)) dut (
    .clk(clk), .rst(rst), .restart(restart), .in_valid(in_valid), .in_byte(in_byte),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_tile(cfg_tile), .cfg_state(cfg_state),
    .cfg_sym(cfg_sym), .cfg_data(cfg_data),
    .out_valid(out_valid), .match_vec(match_vec), .any_match(any_match));

  int checks = 0, errors = 0;
  bit done = 0;

  // pattern set and offline tables
  logic [7:0] pats [NP][4];
  int plen [NP];
  int sel_b [NT][2];
  int nst [NT];
  int st_k [NT][NS];
  int st_l [NT][NS];
  int trans_t [NT][NS][4];
  logic [3:0] pmv_t [NT][NS];

  // reference: byte history of the current packet
  logic [7:0] hist [4];
  int hcnt = 0;
  bit have_exp = 0;
  bit exp_valid = 0;
  logic [3:0] exp_vec = '0;
  string lbl = "R1";

  task automatic chk(input bit ok, input string r, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", r, what, got, exp);
    end
  endtask

  function automatic int proj(input int t, input int k, input int q);
    int v = 0;
    for (int j = 0; j < 2; j++) v |= int'(pats[k][q][sel_b[t][j]]) << j;
    return v;
  endfunction

  // per-tile automata: a state is a distinct projected prefix
  task automatic build();
    for (int t = 0; t < NT; t++) begin
      nst[t] = 0;
      for (int k = 0; k < NP; k++)
        for (int L = 0; L <= plen[k]; L++) begin
          bit found = 0;
          for (int s = 0; s < nst[t]; s++)
            if (st_l[t][s] == L) begin
              bit same = 1;
              for (int q = 0; q < L; q++)
                if (proj(t, st_k[t][s], q) != proj(t, k, q)) same = 0;
              if (same) found = 1;
            end
          if (!found) begin
            st_k[t][nst[t]] = k;
            st_l[t][nst[t]] = L;
            nst[t]++;
          end
        end
      for (int s = 0; s < NS; s++) begin
        pmv_t[t][s] = '0;
        for (int c = 0; c < 4; c++) trans_t[t][s][c] = 0;
        if (s < nst[t]) begin
          int L = st_l[t][s];
          int k = st_k[t][s];
          for (int i = 0; i < NP; i++)
            if (plen[i] <= L) begin
              bit ok = 1;
              for (int q = 0; q < plen[i]; q++)
                if (proj(t, i, q) != proj(t, k, L - plen[i] + q)) ok = 0;
              if (ok) pmv_t[t][s][i] = 1'b1;
            end
          for (int c = 0; c < 4; c++) begin
            int x [5];
            int best = 0, bl = 0;
            for (int q = 0; q < L; q++) x[q] = proj(t, k, q);
            x[L] = c;
            for (int s2 = 0; s2 < nst[t]; s2++) begin
              int l2 = st_l[t][s2];
              if (l2 <= L + 1 && l2 > bl) begin
                bit ok = 1;
                for (int q = 0; q < l2; q++)
                  if (proj(t, st_k[t][s2], q) != x[L + 1 - l2 + q]) ok = 0;
                if (ok) begin best = s2; bl = l2; end
              end
            end
            trans_t[t][s][c] = best;
          end
        end
      end
    end
  endtask

  function automatic logic [3:0] ref_match();
    logic [3:0] m = '0;
    for (int i = 0; i < NP; i++)
      if (hcnt >= plen[i]) begin
        bit ok = 1;
        for (int q = 0; q < plen[i]; q++)
          if (hist[q] != pats[i][plen[i] - 1 - q]) ok = 0;
        m[i] = ok;
      end
    return m;
  endfunction

  // one clock: check the previous cycle's result, then drive this cycle
  task automatic cyc(input bit v, input logic [7:0] b, input bit rs, input bit we,
                     input int kind, input int t, input int s, input int c, input int d,
                     input string base);
    @(negedge clk);
    if (have_exp) begin
      chk(out_valid == exp_valid, lbl, "out_valid", int'(out_valid), int'(exp_valid));
      chk(match_vec == exp_vec, lbl, "match_vec", int'(match_vec), int'(exp_vec));
      chk(any_match == (|exp_vec), "R4", "any_match", int'(any_match), int'(|exp_vec));
    end
    in_valid  = v;
    in_byte   = b;
    restart   = rs;
    cfg_we    = we;
    cfg_kind  = 2'(kind);
    cfg_tile  = 2'(t);
    cfg_state = 4'(s);
    cfg_sym   = 2'(c);
    cfg_data  = 4'(d);
    if (rs) hcnt = 0;
    if (v) begin
      for (int q = 3; q > 0; q--) hist[q] = hist[q-1];
      hist[0] = b;
      if (hcnt < 4) hcnt++;
      exp_vec = ref_match();
    end
    exp_valid = v;
    have_exp  = 1;
    lbl = !v ? "R9" : (rs ? "R5" : base);
  endtask

  // R8: kind 0 next state, kind 1 partial vector, kind 2 selector
  task automatic load(input bit with_sel);
    for (int t = 0; t < NT; t++) begin
      for (int s = 0; s < NS; s++) begin
        for (int c = 0; c < 4; c++) cyc(0, 8'h00, 0, 1, 0, t, s, c, trans_t[t][s][c], "R8");
        cyc(0, 8'h00, 0, 1, 1, t, s, 0, int'(pmv_t[t][s]), "R8");
      end
      if (with_sel)
        for (int j = 0; j < 2; j++) cyc(0, 8'h00, 0, 1, 2, t, 0, j, sel_b[t][j], "R7");
    end
  endtask

  task automatic send_str(input string str, input string base);
    for (int i = 0; i < str.len(); i++)
      cyc(1, str[i], i == 0, 0, 3, 0, 0, 0, 0, base);
  endtask

  task automatic rand_stream(input int n, input string base);
    logic [7:0] alpha [8];
    alpha[0] = "h"; alpha[1] = "e"; alpha[2] = "r"; alpha[3] = "s";
    alpha[4] = "a"; alpha[5] = "i"; alpha[6] = "x"; alpha[7] = "h";
    for (int i = 0; i < n; i++) begin
      int r = int'($urandom % 16);
      if (r == 0)      cyc(0, 8'h00, 0, 0, 3, 0, 0, 0, 0, base);
      else if (r == 1) cyc(0, 8'h00, 1, 0, 3, 0, 0, 0, 0, base);
      else             cyc(1, alpha[$urandom % 8], r == 2, 0, 3, 0, 0, 0, 0, base);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    pats[0][0] = "h"; pats[0][1] = "e"; pats[0][2] = 8'h00; pats[0][3] = 8'h00;
    pats[1][0] = "h"; pats[1][1] = "a"; pats[1][2] = "s";   pats[1][3] = 8'h00;
    pats[2][0] = "h"; pats[2][1] = "i"; pats[2][2] = "s";   pats[2][3] = 8'h00;
    pats[3][0] = "h"; pats[3][1] = "e"; pats[3][2] = "r";   pats[3][3] = "s";
    plen[0] = 2; plen[1] = 3; plen[2] = 3; plen[3] = 4;
    for (int q = 0; q < 4; q++) hist[q] = 8'h00;

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset values
    chk(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
    chk(match_vec == 4'h0, "R1", "match_vec", int'(match_vec), 0);
    chk(any_match == 1'b0, "R1", "any_match", int'(any_match), 0);

    // R1: straight split from reset, no selector writes
    for (int t = 0; t < NT; t++) for (int j = 0; j < 2; j++) sel_b[t][j] = 2*t + j;
    build();
    load(0);
    send_str("ushers", "R1");
    send_str("hishershe", "R3");
    rand_stream(400, "R3");

    // R5: restart cuts a pattern; restart alone returns home
    cyc(1, "h", 1, 0, 3, 0, 0, 0, 0, "R5");
    cyc(1, "e", 1, 0, 3, 0, 0, 0, 0, "R5");
    cyc(1, "h", 0, 0, 3, 0, 0, 0, 0, "R5");
    cyc(0, 8'h00, 1, 0, 3, 0, 0, 0, 0, "R5");
    cyc(1, "e", 0, 0, 3, 0, 0, 0, 0, "R5");
    cyc(1, "r", 0, 0, 3, 0, 0, 0, 0, "R5");

    // R6: writes during streaming must not take effect
    for (int i = 0; i < 48; i++) begin
      int k = i % 3;
      cyc(1, (i % 4 == 0) ? 8'h68 : ((i % 4 == 1) ? 8'h65 : ((i % 4 == 2) ? 8'h72 : 8'h73)),
          i == 0, 1, k, i % 4, i % 16, i % 4, (k == 2) ? 7 : 0, "R6");
    end
    send_str("hershashis", "R6");
    send_str("he", "R6");

    // R7: crossed grouping (8,4),(7,3),(6,5),(2,1) counted from 1
    sel_b[0][0] = 7; sel_b[0][1] = 3;
    sel_b[1][0] = 6; sel_b[1][1] = 2;
    sel_b[2][0] = 5; sel_b[2][1] = 4;
    sel_b[3][0] = 1; sel_b[3][1] = 0;
    build();
    load(1);
    send_str("ushers", "R7");
    send_str("ahishas", "R7");
    rand_stream(400, "R7");
    cyc(0, 8'h00, 0, 0, 3, 0, 0, 0, 0, "R9");
    cyc(0, 8'h00, 0, 0, 3, 0, 0, 0, 0, "R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule